// File: doc/BRIEF.md
# Static RAM Write Strobe Sequencer

This block turns single write requests from a synchronous host into the chip-select, semaphore-select, read/write and byte-select waveforms of an asynchronous static RAM. The RAM also has a separate semaphore space. Every interval is a compile-time number of clock cycles: address setup, strobe overlap, driver turn-off, data setup and write recovery. All pin outputs are registered, so each one changes on a clock edge and is free of glitches.

Each request chooses its target space and its byte lanes. It also chooses the strobe that times the write. In the read/write-timed style the select goes low first and the write line frames the pulse. In the select-timed style the write line goes low first and the select frames the pulse. The host also reports whether the memory's output enable is currently asserted. In the read/write-timed style the pulse then grows, so that the memory's output drivers are off before data is put on the bus. A request with no byte lane enabled completes at once and produces no strobe.

Top module: `sram_wr_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is accepted on a clock edge at which `req_valid` and `req_ready` are both high. For a write, `req_ready` is low for exactly T_AS + N + T_WR cycles after the accepting edge, where N is the pulse length from R5. `req_valid` has no effect while `req_ready` is low.
- R2: `sram_addr` takes the request address on the accepting edge and holds it through recovery. It never changes on an edge at which the write line and the active select were both low.
- R3: In the read/write-timed style (`req_cs_timed`=0), the active select goes low first. T_AS cycles later the write line goes low and stays low for N cycles. The write line then rises, and the select rises T_WR cycles after that.
- R4: In the select-timed style (`req_cs_timed`=1), the write line goes low first. T_AS cycles later the active select goes low and stays low for N cycles. The select then rises, and the write line rises T_WR cycles after that.
- R5: The overlap of both strobes lasts N cycles. N is max(T_WP, T_WZ+T_DW) in the read/write-timed style with `req_oe_n`=0. In every other case N is T_WP.
- R6: `sram_dq_oe` is high only inside the overlap. In the read/write-timed style with `req_oe_n`=0, it rises T_WZ cycles after the overlap begins. In every other case it rises with the overlap. In all cases it falls when the overlap ends. While it is high, `sram_dq_out` carries the request data.
- R7: With `req_sem`=0 the active select is `sram_ce_n` and `sram_sem_n` stays high. With `req_sem`=1 the active select is `sram_sem_n` and `sram_ce_n` stays high. The two are never low together.
- R8: `sram_ub_n` is low exactly while the active select is low and `req_be[1]` was set. `sram_lb_n` follows `req_be[0]` in the same way. Bit 1 is the upper lane, bits 15:8.
- R9: A request with `req_be`=00 produces no strobe and no data drive. `req_ready` is low for exactly one cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Idle, can accept a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_be | input | 2 | Byte lane enables (bit 1 upper) |
| req_sem | input | 1 | 1 = semaphore space, 0 = RAM |
| req_cs_timed | input | 1 | 1 = select-timed write, 0 = read/write-timed |
| req_oe_n | input | 1 | Current memory output-enable level (0 = enabled) |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_dq_out | output | DATA_W | Data to the bus |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_sem_n | output | 1 | Semaphore select, active low |
| sram_we_n | output | 1 | Read/write line, low = write |
| sram_ub_n | output | 1 | Upper byte select, active low |
| sram_lb_n | output | 1 | Lower byte select, active low |

## Verification
The assertions assume that the request fields hold their values on the accepting edge. They also assume the timing parameters are at least one cycle each, so every phase lasts at least one cycle and the pulse-length comparison is meaningful. The stimulus always presents a complete, stable request on the falling clock edge before it is accepted. For one directed case it keeps `req_valid` high with a changed address throughout the busy window and drops it just before idle, to show that input is ignored. The random requests cover every combination of space, lanes, style and output-enable level, including the empty lane mask.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_RECOV,
    PH_NOP
  } phase_e;

  typedef struct packed {
    logic       cs_timed;
    logic       oe_n;
    logic       sem;
    logic [1:0] be;
  } op_ctl_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timing.sv
module sram_wr_timing
  import sram_wr_pkg::*;
#(
  parameter int T_WP = 3,
  parameter int T_WZ = 2,
  parameter int T_DW = 2,
  parameter int CW   = 3
) (
  input  op_ctl_t        ctl,
  output logic [CW-1:0]  pulse_len,
  output logic [CW-1:0]  drive_dly
);
  localparam int LONG_PULSE = imax(T_WP, T_WZ + T_DW);

  always_comb begin
    if (!ctl.cs_timed && !ctl.oe_n) begin
      pulse_len = CW'(LONG_PULSE);
      drive_dly = CW'(T_WZ);
    end else begin
      pulse_len = CW'(T_WP);
      drive_dly = '0;
    end
  end
endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int T_AS   = 1,
  parameter int T_WR   = 2,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  op_ctl_t           req_ctl,
  input  logic [CW-1:0]     pulse_len,
  output logic              ready,
  output phase_e            ph_d,
  output logic [CW-1:0]     cnt_d,
  output op_ctl_t           ctl_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic [DATA_W-1:0] data_d
);
  phase_e            st_q;
  logic [CW-1:0]     cnt_q;
  op_ctl_t           ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign ready  = (st_q == PH_IDLE);
  assign accept = ready && req_valid;

  always_comb begin
    ph_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PH_IDLE: begin
        if (req_valid) begin
          cnt_d = '0;
          ph_d  = (req_ctl.be == 2'b00) ? PH_NOP : PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (cnt_q == CW'(T_AS - 1)) begin
          ph_d  = PH_PULSE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_PULSE: begin
        if (cnt_q == pulse_len - CW'(1)) begin
          ph_d  = PH_RECOV;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_RECOV: begin
        if (cnt_q == CW'(T_WR - 1)) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_NOP:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign ctl_d  = accept ? req_ctl  : ctl_q;
  assign addr_d = accept ? req_addr : addr_q;
  assign data_d = accept ? req_data : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      ctl_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= ph_d;
      cnt_q  <= cnt_d;
      ctl_q  <= ctl_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  // An empty lane mask returns to idle after a single busy cycle
  assert_nop_short_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_NOP) |=> ready);
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            ph_d,
  input  logic [CW-1:0]     cnt_d,
  input  op_ctl_t           ctl_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] data_d,
  input  logic [CW-1:0]     drive_dly,
  input  logic [CW-1:0]     pulse_len,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_sem_n,
  output logic              sram_we_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n
);
  logic busy_d, sel_low_d, we_low_d, drv_d;

  assign busy_d = (ph_d == PH_SETUP) || (ph_d == PH_PULSE) || (ph_d == PH_RECOV);

  always_comb begin
    if (ctl_d.cs_timed) begin
      sel_low_d = (ph_d == PH_PULSE);
      we_low_d  = busy_d;
    end else begin
      sel_low_d = busy_d;
      we_low_d  = (ph_d == PH_PULSE);
    end
    drv_d = (ph_d == PH_PULSE) && (cnt_d >= drive_dly);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      sram_ce_n   <= 1'b1;
      sram_sem_n  <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_ub_n   <= 1'b1;
      sram_lb_n   <= 1'b1;
    end else begin
      sram_addr   <= addr_d;
      sram_dq_out <= data_d;
      sram_dq_oe  <= drv_d;
      sram_ce_n   <= !(sel_low_d && !ctl_d.sem);
      sram_sem_n  <= !(sel_low_d && ctl_d.sem);
      sram_we_n   <= !we_low_d;
      sram_ub_n   <= !(sel_low_d && ctl_d.be[1]);
      sram_lb_n   <= !(sel_low_d && ctl_d.be[0]);
    end
  end

  // Checker state: length of the current strobe overlap
  logic          sel_pin_low, ovl;
  logic [CW-1:0] ovl_run;
  assign sel_pin_low = !sram_ce_n || !sram_sem_n;
  assign ovl         = sel_pin_low && !sram_we_n;

  always_ff @(posedge clk) begin
    if (rst)      ovl_run <= '0;
    else if (ovl) ovl_run <= ovl_run + CW'(1);
    else          ovl_run <= '0;
  end

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sram_addr) |-> ($past(sram_we_n) || ($past(sram_ce_n) && $past(sram_sem_n))));

  assert_rw_order_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(sram_we_n) && !ctl_d.cs_timed) |-> $past(sel_pin_low));

  assert_cs_order_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(sel_pin_low) && ctl_d.cs_timed) |-> $past(!sram_we_n));

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(ovl) && !ovl) |-> (ovl_run == pulse_len));

  assert_drive_in_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> ovl);

  assert_one_space_R7: assert property (@(posedge clk) disable iff (rst)
    !(!sram_ce_n && !sram_sem_n));

  assert_byte_with_sel_R8: assert property (@(posedge clk) disable iff (rst)
    (!sram_ub_n || !sram_lb_n) |-> sel_pin_low);
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int T_AS   = 1,
  parameter int T_WP   = 3,
  parameter int T_WZ   = 2,
  parameter int T_DW   = 2,
  parameter int T_WR   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_be,
  input  logic              req_sem,
  input  logic              req_cs_timed,
  input  logic              req_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_sem_n,
  output logic              sram_we_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n
);
  localparam int LONG_PULSE = imax(T_WP, T_WZ + T_DW);
  localparam int CNT_MAX    = imax(imax(T_AS, LONG_PULSE), T_WR);
  localparam int CW         = $clog2(CNT_MAX + 1);

  op_ctl_t           req_ctl, ctl_d;
  phase_e            ph_d;
  logic [CW-1:0]     cnt_d, pulse_len, drive_dly;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  assign req_ctl = '{cs_timed: req_cs_timed, oe_n: req_oe_n,
                     sem: req_sem, be: req_be};

  sram_wr_timing #(.T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW), .CW(CW)) u_timing (
    .ctl(ctl_d), .pulse_len(pulse_len), .drive_dly(drive_dly)
  );

  sram_wr_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_AS(T_AS), .T_WR(T_WR),
                .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ctl(req_ctl), .pulse_len(pulse_len),
    .ready(req_ready), .ph_d(ph_d), .cnt_d(cnt_d), .ctl_d(ctl_d),
    .addr_d(addr_d), .data_d(data_d)
  );

  sram_wr_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW)) u_pins (
    .clk(clk), .rst(rst), .ph_d(ph_d), .cnt_d(cnt_d), .ctl_d(ctl_d),
    .addr_d(addr_d), .data_d(data_d), .drive_dly(drive_dly),
    .pulse_len(pulse_len), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n), .sram_sem_n(sram_sem_n),
    .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n)
  );

  // Busy ends only after the full setup, pulse and recovery span
  assert_ready_idle_strobes_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_we_n && sram_ce_n && sram_sem_n && !sram_dq_oe));
endmodule

// File: tb/sram_wr_seq_test.sv
module sram_wr_seq_test;
  localparam int AW = 12, DW = 16;
  localparam int T_AS = 1, T_WP = 3, T_WZ = 2, T_DW = 2, T_WR = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0] req_be = '0;
  logic req_sem = 0, req_cs_timed = 0, req_oe_n = 1;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dq_out;
  logic sram_dq_oe, sram_ce_n, sram_sem_n, sram_we_n, sram_ub_n, sram_lb_n;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP),
                .T_WZ(T_WZ), .T_DW(T_DW), .T_WR(T_WR)) uut (.*);

  function automatic int exp_len(bit cs, bit oe_n);
    if (!cs && !oe_n) return (T_WP > T_WZ + T_DW) ? T_WP : T_WZ + T_DW;
    return T_WP;
  endfunction

  task automatic check(string tag, int cyc, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, got, exp);
    end
  endtask

  task automatic run_req(logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] be,
                         bit sem, bit cs, bit oe_n, bit hold);
    int n, tot, dly, ovl;
    bit setup, pulse, recov, idle, sel_low, we_low, drv;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d; req_be = be;
    req_sem = sem; req_cs_timed = cs; req_oe_n = oe_n;
    @(posedge clk);
    if (be == 2'b00) begin
      @(negedge clk);
      req_valid = 0;
      check("R9 ready", 1, req_ready, 0);
      check("R9 strobes", 1, {sram_we_n, sram_ce_n, sram_sem_n, sram_ub_n,
                              sram_lb_n, sram_dq_oe}, 6'b111110);
      @(negedge clk);
      check("R9 ready back", 2, req_ready, 1);
      return;
    end
    n = exp_len(cs, oe_n);
    tot = T_AS + n + T_WR;
    dly = (!cs && !oe_n) ? T_WZ : 0;
    ovl = 0;
    for (int i = 1; i <= tot + 1; i++) begin
      @(negedge clk);
      setup = (i <= T_AS);
      pulse = (i > T_AS) && (i <= T_AS + n);
      recov = (i > T_AS + n) && (i <= tot);
      idle  = (i > tot);
      sel_low = cs ? pulse : (setup || pulse || recov);
      we_low  = cs ? (setup || pulse || recov) : pulse;
      drv = pulse && ((i - T_AS - 1) >= dly);
      check("R1 ready", i, req_ready, idle);
      check("R2 addr", i, sram_addr, a);
      check(cs ? "R4 we_n" : "R3 we_n", i, sram_we_n, !we_low);
      check(cs ? "R4 select" : "R3 select", i, sram_ce_n & sram_sem_n, !sel_low);
      check("R7 ce_n", i, sram_ce_n, !(sel_low && !sem));
      check("R7 sem_n", i, sram_sem_n, !(sel_low && sem));
      check("R8 ub_n", i, sram_ub_n, !(sel_low && be[1]));
      check("R8 lb_n", i, sram_lb_n, !(sel_low && be[0]));
      check("R6 dq_oe", i, sram_dq_oe, drv);
      if (drv) check("R6 dq_out", i, sram_dq_out, d);
      if (!sram_we_n && (!sram_ce_n || !sram_sem_n)) ovl++;
      if (i == 1 && !hold) req_valid = 0;
      if (i == 1 && hold) begin req_addr = ~a; req_data = ~d; req_be = ~be; end
      if (i == tot && hold) req_valid = 0;
    end
    check("R5 pulse length", 0, ovl, n);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset ready", 0, req_ready, 1);
    check("R1 reset strobes", 0, {sram_we_n, sram_ce_n, sram_sem_n, sram_ub_n,
                                  sram_lb_n, sram_dq_oe}, 6'b111110);
    // directed corners
    run_req(12'h0A5, 16'hBEEF, 2'b11, 0, 0, 0, 0); // long pulse, late drive
    run_req(12'h123, 16'h0001, 2'b01, 1, 0, 1, 0); // short pulse, semaphore
    run_req(12'hFFF, 16'hA55A, 2'b10, 0, 1, 0, 0); // select-timed
    run_req(12'h3C3, 16'h1234, 2'b11, 1, 1, 1, 1); // busy-time valid ignored
    run_req(12'h777, 16'hFFFF, 2'b00, 0, 0, 0, 0); // empty mask
    run_req(12'h001, 16'h8001, 2'b01, 0, 0, 0, 1); // hold, long pulse
    for (int k = 0; k < 80; k++) begin
      logic [31:0] r;
      r = $urandom;
      run_req(AW'($urandom), DW'($urandom), r[1:0], r[2], r[3], r[4], r[5]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule